// File: doc/BRIEF.md
# Dual Power-Good Aggregator

This block folds a set of protection fault flags into two power-good indications. Eight primary fault flags reach both outputs. These flags are soft start, fast overcurrent on sense 1, accurate overcurrent on sense 1, accurate overcurrent on sense 2, undervoltage, local overvoltage, load overvoltage, and OR-ing FET gate fault. Each output has its own mask over the primary flags. Five secondary flags reach only the second output. These flags are voltage continuity, OR-ing FET disable, AC sense, external flag input and overtemperature. A qualify bit chooses how a secondary flag counts. It either counts whenever it is active, or it counts only when its configured 2-bit fault action is not "ignore" (code 0).

Each output's raw fault condition passes through its own debounce filter, with a 2-bit hold-time select. The filtered value drives a status bit, active high for power good. It also drives an open-drain pull-down enable, active high to pull the pin low. Configuration is written through a simple write port. The fault detectors are outside this block.

Top module: `pwr_good_agg`

## Requirements
- R1: All configuration registers reset to zero. A write with `wr_en` high updates the addressed register on that clock edge. Address 0 holds the output-1 mask and address 1 holds the output-2 mask. Address 2 holds the control fields: bit 0 is the qualify mode, bits 2:1 are the output-1 debounce select, and bits 4:3 are the output-2 debounce select. Address 3 holds the fault actions of secondary flags 0..3, two bits each with flag 0 in bits 1:0. Address 4 holds the action of secondary flag 4 in bits 1:0.
- R2: The raw output-1 fault is active when any primary flag is high whose output-1 mask bit is 0. A mask bit of 1 stops that flag from affecting output 1.
- R3: The raw output-2 primary term is active when any primary flag is high whose output-2 mask bit is 0. This mask is independent of the output-1 mask.
- R4: Secondary flags never affect output 1.
- R5: With the qualify mode at 0, any active secondary flag makes output 2 indicate fault, whatever its action code.
- R6: With the qualify mode at 1, an active secondary flag makes output 2 indicate fault only if its 2-bit action code is nonzero.
- R7: Each filtered output changes only after its raw condition has differed from it for the selected number of consecutive cycles. Debounce codes 0, 1, 2 and 3 select 1, 4, 16 and 64 cycles by default. A shorter disagreement leaves the output unchanged.
- R8: During and just after reset, both outputs indicate fault, until the raw condition has been clear for the selected hold time.
- R9: For each output, the good status is high exactly when the pull-down enable is low. The pull-down enable is high while the filtered fault is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| main_flags | input | 8 | Primary fault flags, active high |
| extra_flags | input | 5 | Secondary fault flags, active high |
| pg1_good | output | 1 | Output-1 power-good status (1 = good) |
| pg2_good | output | 1 | Output-2 power-good status (1 = good) |
| pg1_pulldown | output | 1 | Output-1 open-drain pull-low enable |
| pg2_pulldown | output | 1 | Output-2 open-drain pull-low enable |

## Verification
The primary flags are driven with all masks clear first, and then with single bits masked on one output only. This separates the two mask registers and shows that a mask on one output does not leak into the other. Secondary flags are applied with every action code at zero in both qualify modes, and then with nonzero actions on a low-numbered flag and on the flag held in the upper action register. This tells the unconditional path apart from the qualified one, and checks the split of the action field across two registers. The debounce is driven with a pulse one cycle shorter than the hold time and then with a sustained fault. Output 1 and output 2 use different hold codes, which shows that the two hold counts are separate.

// File: rtl/pga_pkg.sv
package pga_pkg;
    localparam int NMAIN  = 8;
    localparam int NEXTRA = 5;
    localparam int ACTW   = 2 * NEXTRA;
    localparam int DBW    = 2;

    typedef enum logic [2:0] {
        ADDR_MASK_A = 3'd0,
        ADDR_MASK_B = 3'd1,
        ADDR_CTRL   = 3'd2,
        ADDR_ACT_LO = 3'd3,
        ADDR_ACT_HI = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NMAIN-1:0] mask_a;
        logic [NMAIN-1:0] mask_b;
        logic             qual_mode;
        logic [DBW-1:0]   dbsel_a;
        logic [DBW-1:0]   dbsel_b;
        logic [ACTW-1:0]  action;
    } cfg_t;
endpackage

// File: rtl/pga_regs.sv
module pga_regs
    import pga_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output cfg_t        cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_MASK_A: cfg_d.mask_a = wr_data[NMAIN-1:0];
                ADDR_MASK_B: cfg_d.mask_b = wr_data[NMAIN-1:0];
                ADDR_CTRL: begin
                    cfg_d.qual_mode = wr_data[0];
                    cfg_d.dbsel_a   = wr_data[2:1];
                    cfg_d.dbsel_b   = wr_data[4:3];
                end
                ADDR_ACT_LO: cfg_d.action[7:0]      = wr_data;
                ADDR_ACT_HI: cfg_d.action[ACTW-1:8] = wr_data[ACTW-9:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_MASK_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (cfg.mask_a == $past(wr_data))); // R1
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd2) |=> (cfg.dbsel_b == $past(wr_data[4:3]))); // R1
endmodule

// File: rtl/pga_combine.sv
module pga_combine
    import pga_pkg::*;
(
    input  logic [NMAIN-1:0]  main_flags,
    input  logic [NEXTRA-1:0] extra_flags,
    input  cfg_t              cfg,
    output logic              raw_a,
    output logic              raw_b
);
    logic [NEXTRA-1:0] counts;

    for (genvar i = 0; i < NEXTRA; i++) begin : g_qual
        assign counts[i] = !cfg.qual_mode || (cfg.action[2*i +: 2] != 2'b00);
    end

    always_comb begin
        raw_a = |(main_flags & ~cfg.mask_a);
        raw_b = |(main_flags & ~cfg.mask_b) | |(extra_flags & counts);
    end
endmodule

// File: rtl/pga_debounce.sv
module pga_debounce #(
    parameter int HOLD0 = 1,
    parameter int HOLD1 = 4,
    parameter int HOLD2 = 16,
    parameter int HOLD3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [1:0] sel,
    output logic       filt
);
    localparam int HM01 = (HOLD0 > HOLD1) ? HOLD0 : HOLD1;
    localparam int HM23 = (HOLD2 > HOLD3) ? HOLD2 : HOLD3;
    localparam int HMAX = (HM01 > HM23) ? HM01 : HM23;
    localparam int CW   = $clog2(HMAX + 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    int  lim;

    always_comb begin
        case (sel)
            2'd0:    lim = HOLD0;
            2'd1:    lim = HOLD1;
            2'd2:    lim = HOLD2;
            default: lim = HOLD3;
        endcase
        st_d = st_q;
        if (raw == st_q.filt) begin
            st_d.cnt = '0;
        end else if (int'(st_q.cnt) >= lim - 1) begin
            st_d.filt = raw;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.filt <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.filt;

    AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == filt) |=> $stable(filt)); // R7
    AST_FILT_TAKES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(raw))); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < HMAX); // R7
endmodule

// File: rtl/pwr_good_agg.sv
module pwr_good_agg
    import pga_pkg::*;
#(
    parameter int HOLD0 = 1,
    parameter int HOLD1 = 4,
    parameter int HOLD2 = 16,
    parameter int HOLD3 = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  main_flags,
    input  logic [4:0]  extra_flags,
    output logic        pg1_good,
    output logic        pg2_good,
    output logic        pg1_pulldown,
    output logic        pg2_pulldown
);
    localparam int NOUT = 2;

    cfg_t           cfg;
    logic           raw_a, raw_b;
    logic [NOUT-1:0] raw_v;
    logic [NOUT-1:0] filt_v;
    logic [1:0]     sel_v [NOUT];

    pga_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    pga_combine u_comb (
        .main_flags  (main_flags),
        .extra_flags (extra_flags),
        .cfg         (cfg),
        .raw_a       (raw_a),
        .raw_b       (raw_b)
    );

    assign raw_v    = {raw_b, raw_a};
    assign sel_v[0] = cfg.dbsel_a;
    assign sel_v[1] = cfg.dbsel_b;

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        pga_debounce #(
            .HOLD0 (HOLD0),
            .HOLD1 (HOLD1),
            .HOLD2 (HOLD2),
            .HOLD3 (HOLD3)
        ) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[k]),
            .sel   (sel_v[k]),
            .filt  (filt_v[k])
        );
    end

    assign pg1_pulldown = filt_v[0];
    assign pg2_pulldown = filt_v[1];
    assign pg1_good     = !filt_v[0];
    assign pg2_good     = !filt_v[1];

    AST_MASKED_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_flags & ~cfg.mask_a) == '0) |-> !raw_a); // R2
    AST_UNMASKED_B_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_flags & ~cfg.mask_b) != '0) |-> raw_b); // R3
    AST_EXTRA_NOT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (main_flags == '0) |-> !raw_a); // R4
    AST_MODE0_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.qual_mode && extra_flags != '0) |-> raw_b); // R5
    AST_MODE1_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.qual_mode && cfg.action == '0 && ((main_flags & ~cfg.mask_b) == '0)) |-> !raw_b); // R6
endmodule

// File: tb/pwr_good_agg_test.sv
module pwr_good_agg_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] main_flags = '0;
    logic [4:0] extra_flags = '0;
    logic       pg1_good, pg2_good, pg1_pulldown, pg2_pulldown;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  g1;
        logic  g2;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_good_agg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .main_flags   (main_flags),
        .extra_flags  (extra_flags),
        .pg1_good     (pg1_good),
        .pg2_good     (pg2_good),
        .pg1_pulldown (pg1_pulldown),
        .pg2_pulldown (pg2_pulldown)
    );

    task automatic expect_out(input logic g1, input logic g2, input string tag);
        exp_t e;
        e.g1 = g1; e.g2 = g2; e.tag = tag;
        sb_q.push_back(e);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (pg1_good !== e.g1 || pg2_good !== e.g2) begin
                    failures++;
                    $display("FAIL %s: good1/good2 actual %b%b expected %b%b",
                             e.tag, pg1_good, pg2_good, e.g1, e.g2);
                end
                checks++;
                if (pg1_pulldown !== !e.g1 || pg2_pulldown !== !e.g2) begin // R9
                    failures++;
                    $display("FAIL R9 (%s): pulldown1/2 actual %b%b expected %b%b",
                             e.tag, pg1_pulldown, pg2_pulldown, !e.g1, !e.g2);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        expect_out(1'b0, 1'b0, "R8 in reset");
        rst_n = 1'b1;
        cycles(2);
        expect_out(1'b1, 1'b1, "R8 R1 after reset clear");

        main_flags = 8'h01;
        cycles(2);
        expect_out(1'b0, 1'b0, "R2 R3 unmasked flag");

        wr(3'd0, 8'h01);
        cycles(1);
        expect_out(1'b1, 1'b0, "R1 R2 mask on output 1 only");

        main_flags = 8'h80;
        wr(3'd1, 8'hFF);
        cycles(1);
        expect_out(1'b0, 1'b1, "R3 mask on output 2 only");

        main_flags = 8'h00;
        extra_flags = 5'b00100;
        cycles(2);
        expect_out(1'b1, 1'b0, "R4 R5 extra flag mode 0");

        wr(3'd2, 8'h01);
        cycles(1);
        expect_out(1'b1, 1'b1, "R6 mode 1 action ignore");

        wr(3'd3, 8'b0010_0000);
        cycles(1);
        expect_out(1'b1, 1'b0, "R6 mode 1 action nonzero");

        extra_flags = 5'b10000;
        cycles(2);
        expect_out(1'b1, 1'b1, "R6 flag 4 action ignore");

        wr(3'd4, 8'h01);
        cycles(1);
        expect_out(1'b1, 1'b0, "R1 R6 flag 4 action nonzero");

        wr(3'd2, 8'h00);
        wr(3'd4, 8'h00);
        cycles(1);
        expect_out(1'b1, 1'b0, "R5 mode 0 ignores action");

        extra_flags = 5'b00000;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h0C);
        cycles(1);
        expect_out(1'b1, 1'b1, "R7 idle before debounce");

        main_flags = 8'h02;
        cycles(3);
        expect_out(1'b1, 1'b1, "R7 short pulse held off");
        main_flags = 8'h00;
        cycles(1);
        expect_out(1'b1, 1'b1, "R7 short pulse dropped");

        main_flags = 8'h02;
        cycles(3);
        expect_out(1'b1, 1'b1, "R7 output 2 before 4 cycles");
        cycles(1);
        expect_out(1'b1, 1'b0, "R7 output 2 at 4 cycles");
        cycles(11);
        expect_out(1'b1, 1'b0, "R7 output 1 before 16 cycles");
        cycles(1);
        expect_out(1'b0, 1'b0, "R7 output 1 at 16 cycles");

        main_flags = 8'h00;
        cycles(4);
        expect_out(1'b0, 1'b1, "R7 output 2 release at 4 cycles");
        cycles(12);
        expect_out(1'b1, 1'b1, "R7 output 1 release at 16 cycles");

        cycles(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule